// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block keeps wall-clock time and a calendar date in packed BCD: seconds, minutes, hours (24-hour), a weekday number, day of month, month and a two-digit year standing for 2000 to 2099. It does not divide a crystal clock itself. An external prescaler hands it a one-cycle pulse once per second. When counting is enabled, each pulse moves the time forward, and the block handles every carry between fields. That includes the length of each month and the extra February day in leap years.

The time fields settle at the clock edge that samples the tick. A carry out of 23:59:59 is held for one cycle by a two-state sequencer. That sequencer has state `S_TRACK`, the idle state that follows the time fields, and state `S_DATE_STEP`, in which day, weekday, month and year advance. The transitions are: `S_TRACK -> S_DATE_STEP` when an enabled tick wraps the time of day, and `S_DATE_STEP -> S_TRACK` unconditionally on the next edge, unless a fresh wrap occurs there too. A busy output is high while the sequencer sits in `S_DATE_STEP`, so software reading the fields can tell that the date is not yet consistent with the time.

Every field has its own load strobe and data port. Loads only take effect while the write-unlock input is high.

Top module: `bcd_calendar`

## Requirements
- R1: Seconds and minutes count 00 to 59 in packed BCD ({tens[2:0], ones[3:0]}). The ones digit carries into the tens digit when it passes 9, and 59 wraps to 00 with a carry into the next field.
- R2: Hours count 00 to 23 in BCD ({tens[1:0], ones[3:0]}). An enabled tick at 23:59:59 gives 00:00:00 on the next edge and raises a carry into the date.
- R3: The date fields change exactly one cycle after the time fields wrap. The busy output is high for exactly that one cycle (state `S_DATE_STEP`) and low otherwise.
- R4: The weekday (3 bits, 0 = Sunday through 6 = Saturday) advances on the same date step as the day. It wraps from 6 to 0 and carries into no other field.
- R5: The day (BCD {tens[1:0], ones[3:0]}) runs from 01 to the month's last day. The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. After the last day the day returns to 01 and the month (BCD {tens, ones[3:0]}) advances.
- R6: February ends on day 29 when the BCD year is divisible by 4, and on day 28 otherwise.
- R7: A date step from month 12 day 31 gives 01/01 and advances the year. Year 99 wraps to 00.
- R8: A load strobe is ignored while the write-unlock input is low. The field keeps its value.
- R9: A load with write-unlock high replaces the field at the next clock edge, even if a tick or date step would have changed it, and counting continues from the loaded value.
- R10: Ticks are ignored while the run enable is low.
- R11: After reset the fields read 00:00:00, weekday 6, day 01, month 01, year 00, and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| run_en | input | 1 | Counting enable |
| wr_unlock | input | 1 | Permits field loads |
| ld_sec | input | 1 | Load strobe, seconds |
| sec_in | input | 7 | Seconds load value (BCD) |
| ld_min | input | 1 | Load strobe, minutes |
| min_in | input | 7 | Minutes load value (BCD) |
| ld_hour | input | 1 | Load strobe, hours |
| hour_in | input | 6 | Hours load value (BCD) |
| ld_wday | input | 1 | Load strobe, weekday |
| wday_in | input | 3 | Weekday load value |
| ld_day | input | 1 | Load strobe, day |
| day_in | input | 6 | Day load value (BCD) |
| ld_month | input | 1 | Load strobe, month |
| month_in | input | 5 | Month load value (BCD) |
| ld_year | input | 1 | Load strobe, year |
| year_in | input | 8 | Year load value (BCD) |
| sec_q | output | 7 | Seconds |
| min_q | output | 7 | Minutes |
| hour_q | output | 6 | Hours |
| wday_q | output | 3 | Weekday |
| day_q | output | 6 | Day of month |
| month_q | output | 5 | Month |
| year_q | output | 8 | Year |
| busy | output | 1 | Date carry pending |

## Verification
Loads and the time-of-day update are due one edge after the strobe or tick. The bench drives inputs on the falling edge and samples on the next falling edge. For a wrap at midnight, the bench checks three things at that first falling edge: the new time, a high busy flag and an unchanged date. One edge later it checks the advanced date and a low busy flag. The date-rollover cases (every month end, February in years 00, 01 and 04, and the end of year 99) are expected values computed in the bench from calendar rules, not taken from the design.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int SEC_W   = 7;
    localparam int MIN_W   = 7;
    localparam int HOUR_W  = 6;
    localparam int WDAY_W  = 3;
    localparam int DAY_W   = 6;
    localparam int MONTH_W = 5;
    localparam int YEAR_W  = 8;

    typedef enum logic [0:0] {
        S_TRACK     = 1'b0,
        S_DATE_STEP = 1'b1
    } seq_state_t;

    // BCD year divisible by four: even tens with ones 0/4/8, odd tens with ones 2/6
    function automatic logic leap_bcd(input logic [YEAR_W-1:0] yr);
        logic [3:0] ones;
        ones = yr[3:0];
        if (yr[4] == 1'b0)
            leap_bcd = (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
        else
            leap_bcd = (ones == 4'd2) || (ones == 4'd6);
    endfunction

    function automatic logic [DAY_W-1:0] month_end(input logic [MONTH_W-1:0] mo,
                                                   input logic [YEAR_W-1:0]  yr);
        unique case (mo)
            5'h02:                      month_end = leap_bcd(yr) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: month_end = 6'h30;
            default:                    month_end = 6'h31;
        endcase
    endfunction
endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
    parameter int              TENS_W = 3,
    parameter logic [TENS_W+3:0] LOW  = '0,
    parameter logic [TENS_W+3:0] RST  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              ld_ok,
    input  logic [TENS_W+3:0] ld_val,
    input  logic [TENS_W+3:0] top,
    output logic [TENS_W+3:0] q,
    output logic              at_top
);
    localparam int W = TENS_W + 4;

    logic [W-1:0] q_next;
    logic [TENS_W-1:0] tens;
    logic [3:0] ones;

    assign tens   = q[W-1:4];
    assign ones   = q[3:0];
    assign at_top = (q == top);

    always_comb begin
        q_next = q;
        if (ld_ok)
            q_next = ld_val;
        else if (inc) begin
            if (at_top)
                q_next = LOW;
            else if (ones == 4'd9)
                q_next = {tens + 1'b1, 4'd0};
            else
                q_next = {tens, ones + 4'd1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST;
        else
            q <= q_next;
    end

    AST_ONES_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_ok |=> (q[3:0] <= 4'd9)); // R1
    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_ok && !inc) |=> $stable(q)); // R8
    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld_ok) |=> (q != $past(q))); // R1
endmodule

// File: rtl/cal_seq.sv
module cal_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic day_carry,
    output logic date_step,
    output logic busy
);
    import cal_pkg::*;

    seq_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_TRACK:     state_nx = day_carry ? S_DATE_STEP : S_TRACK;
            S_DATE_STEP: state_nx = day_carry ? S_DATE_STEP : S_TRACK;
            default:     state_nx = S_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_TRACK;
        else
            state <= state_nx;
    end

    always_comb begin
        date_step = 1'b0;
        busy      = 1'b0;
        unique case (state)
            S_TRACK:     begin date_step = 1'b0; busy = 1'b0; end
            S_DATE_STEP: begin date_step = 1'b1; busy = 1'b1; end
            default:     begin date_step = 1'b0; busy = 1'b0; end
        endcase
    end

    AST_STEP_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        day_carry |=> busy); // R3
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
    parameter logic [2:0] RST_WDAY = 3'd6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       run_en,
    input  logic       wr_unlock,
    input  logic       ld_sec,
    input  logic [6:0] sec_in,
    input  logic       ld_min,
    input  logic [6:0] min_in,
    input  logic       ld_hour,
    input  logic [5:0] hour_in,
    input  logic       ld_wday,
    input  logic [2:0] wday_in,
    input  logic       ld_day,
    input  logic [5:0] day_in,
    input  logic       ld_month,
    input  logic [4:0] month_in,
    input  logic       ld_year,
    input  logic [7:0] year_in,
    output logic [6:0] sec_q,
    output logic [6:0] min_q,
    output logic [5:0] hour_q,
    output logic [2:0] wday_q,
    output logic [5:0] day_q,
    output logic [4:0] month_q,
    output logic [7:0] year_q,
    output logic       busy
);
    import cal_pkg::*;

    localparam logic [2:0] WDAY_LAST = 3'd6;

    logic sec_inc, min_inc, hour_inc, day_carry;
    logic sec_top, min_top, hour_top;
    logic date_step, day_inc, month_inc, year_inc;
    logic day_top, month_top, year_top;
    logic [DAY_W-1:0] day_end;

    assign sec_inc   = sec_tick & run_en;
    assign min_inc   = sec_inc & sec_top;
    assign hour_inc  = min_inc & min_top;
    assign day_carry = hour_inc & hour_top;

    cal_bcd_field #(.TENS_W(3), .LOW(7'h00), .RST(7'h00)) u_sec (
        .clk(clk), .rst_n(rst_n), .inc(sec_inc), .ld_ok(ld_sec & wr_unlock),
        .ld_val(sec_in), .top(7'h59), .q(sec_q), .at_top(sec_top));

    cal_bcd_field #(.TENS_W(3), .LOW(7'h00), .RST(7'h00)) u_min (
        .clk(clk), .rst_n(rst_n), .inc(min_inc), .ld_ok(ld_min & wr_unlock),
        .ld_val(min_in), .top(7'h59), .q(min_q), .at_top(min_top));

    cal_bcd_field #(.TENS_W(2), .LOW(6'h00), .RST(6'h00)) u_hour (
        .clk(clk), .rst_n(rst_n), .inc(hour_inc), .ld_ok(ld_hour & wr_unlock),
        .ld_val(hour_in), .top(6'h23), .q(hour_q), .at_top(hour_top));

    cal_seq u_seq (
        .clk(clk), .rst_n(rst_n), .day_carry(day_carry),
        .date_step(date_step), .busy(busy));

    assign day_end   = month_end(month_q, year_q);
    assign day_inc   = date_step;
    assign month_inc = date_step & day_top;
    assign year_inc  = month_inc & month_top;

    cal_bcd_field #(.TENS_W(2), .LOW(6'h01), .RST(6'h01)) u_day (
        .clk(clk), .rst_n(rst_n), .inc(day_inc), .ld_ok(ld_day & wr_unlock),
        .ld_val(day_in), .top(day_end), .q(day_q), .at_top(day_top));

    cal_bcd_field #(.TENS_W(1), .LOW(5'h01), .RST(5'h01)) u_month (
        .clk(clk), .rst_n(rst_n), .inc(month_inc), .ld_ok(ld_month & wr_unlock),
        .ld_val(month_in), .top(5'h12), .q(month_q), .at_top(month_top));

    cal_bcd_field #(.TENS_W(4), .LOW(8'h00), .RST(8'h00)) u_year (
        .clk(clk), .rst_n(rst_n), .inc(year_inc), .ld_ok(ld_year & wr_unlock),
        .ld_val(year_in), .top(8'h99), .q(year_q), .at_top(year_top));

    always_ff @(posedge clk) begin
        if (!rst_n)
            wday_q <= RST_WDAY;
        else if (ld_wday && wr_unlock)
            wday_q <= wday_in;
        else if (date_step)
            wday_q <= (wday_q == WDAY_LAST) ? 3'd0 : wday_q + 3'd1;
    end

    AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_wday && wr_unlock) |=> (wday_q <= WDAY_LAST)); // R4
    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(ld_sec || ld_min || ld_hour)) |=> !busy); // R3
    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $past(sec_tick && run_en)); // R3
    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (year_inc && year_top && !(ld_year && wr_unlock)) |=> (year_q == 8'h00)); // R7
endmodule

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 0, run_en = 0, wr_unlock = 0;
    logic ld_sec = 0, ld_min = 0, ld_hour = 0, ld_wday = 0, ld_day = 0, ld_month = 0, ld_year = 0;
    logic [6:0] sec_in = 0, min_in = 0;
    logic [5:0] hour_in = 0, day_in = 0;
    logic [2:0] wday_in = 0;
    logic [4:0] month_in = 0;
    logic [7:0] year_in = 0;
    logic [6:0] sec_q, min_q;
    logic [5:0] hour_q, day_q;
    logic [2:0] wday_q;
    logic [4:0] month_q;
    logic [7:0] year_q;
    logic busy;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bcd_calendar u0 (.*);

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_all(input int y, input int mo, input int d, input int wd,
                           input int h, input int mi, input int s);
        @(negedge clk);
        wr_unlock = 1;
        {ld_sec, ld_min, ld_hour, ld_wday, ld_day, ld_month, ld_year} = 7'h7f;
        sec_in = 7'(bcd(s)); min_in = 7'(bcd(mi)); hour_in = 6'(bcd(h));
        wday_in = 3'(wd); day_in = 6'(bcd(d)); month_in = 5'(bcd(mo)); year_in = bcd(y);
        @(negedge clk);
        {ld_sec, ld_min, ld_hour, ld_wday, ld_day, ld_month, ld_year} = 7'h00;
        wr_unlock = 0;
    endtask

    task automatic tick_once();
        @(negedge clk);
        sec_tick = 1;
        @(negedge clk);
        sec_tick = 0;
    endtask

    task automatic t_reset();
        check("R11 sec", 8'(sec_q), 8'h00);
        check("R11 hour", 8'(hour_q), 8'h00);
        check("R11 wday", 8'(wday_q), 8'h06);
        check("R11 day", 8'(day_q), 8'h01);
        check("R11 month", 8'(month_q), 8'h01);
        check("R11 year", year_q, 8'h00);
        check("R11 busy", 8'(busy), 8'h00);
    endtask

    task automatic t_seconds();
        set_all(10, 6, 15, 1, 8, 0, 9);
        tick_once();
        check("R1 ones carry", 8'(sec_q), 8'h10);
        set_all(10, 6, 15, 1, 8, 0, 59);
        tick_once();
        check("R1 sec wrap", 8'(sec_q), 8'h00);
        check("R1 min carry", 8'(min_q), 8'h01);
        set_all(10, 6, 15, 1, 9, 59, 59);
        tick_once();
        check("R2 hour carry", 8'(hour_q), 8'h10);
        check("R2 no day carry busy", 8'(busy), 8'h00);
    endtask

    task automatic t_midnight();
        set_all(21, 3, 5, 2, 23, 59, 59);
        tick_once();
        check("R2 time zero", {1'b0, sec_q | min_q | {1'b0, hour_q}}, 8'h00);
        check("R3 busy high", 8'(busy), 8'h01);
        check("R3 day not yet", 8'(day_q), 8'h05);
        @(negedge clk);
        check("R3 busy low", 8'(busy), 8'h00);
        check("R2 day advanced", 8'(day_q), 8'h06);
        check("R4 wday advanced", 8'(wday_q), 8'h03);
        check("R5 month held", 8'(month_q), 8'h03);
    endtask

    task automatic t_wday_wrap();
        set_all(21, 3, 10, 6, 23, 59, 59);
        tick_once();
        @(negedge clk);
        check("R4 wday 6->0", 8'(wday_q), 8'h00);
        check("R4 year untouched", year_q, 8'h21);
    endtask

    task automatic t_months();
        for (int m = 1; m <= 12; m++) begin
            set_all(1, m, mdays(m, 1) - 1, 0, 23, 59, 59);
            tick_once();
            @(negedge clk);
            check("R5 penultimate", 8'(day_q), bcd(mdays(m, 1)));
            set_all(1, m, mdays(m, 1), 0, 23, 59, 59);
            tick_once();
            @(negedge clk);
            check("R5 day to 01", 8'(day_q), 8'h01);
            check("R5 next month", 8'(month_q), bcd(m == 12 ? 1 : m + 1));
        end
    endtask

    task automatic t_february();
        int yrs[3] = '{0, 1, 4};
        foreach (yrs[i]) begin
            set_all(yrs[i], 2, 28, 0, 23, 59, 59);
            tick_once();
            @(negedge clk);
            if (yrs[i] % 4 == 0) begin
                check("R6 leap feb 29", 8'(day_q), 8'h29);
                check("R6 leap stays feb", 8'(month_q), 8'h02);
                set_all(yrs[i], 2, 29, 0, 23, 59, 59);
                tick_once();
                @(negedge clk);
            end
            check("R6 march 1 day", 8'(day_q), 8'h01);
            check("R6 march 1 month", 8'(month_q), 8'h03);
        end
    endtask

    task automatic t_century();
        set_all(99, 12, 31, 4, 23, 59, 59);
        tick_once();
        @(negedge clk);
        check("R7 year 99->00", year_q, 8'h00);
        check("R7 month 01", 8'(month_q), 8'h01);
        check("R7 day 01", 8'(day_q), 8'h01);
        set_all(45, 12, 31, 4, 23, 59, 59);
        tick_once();
        @(negedge clk);
        check("R7 year carry", year_q, 8'h46);
    endtask

    task automatic t_lock();
        set_all(30, 7, 7, 3, 12, 34, 15);
        @(negedge clk);
        ld_sec = 1; sec_in = 7'h33; ld_year = 1; year_in = 8'h77;
        @(negedge clk);
        ld_sec = 0; ld_year = 0;
        check("R8 sec locked", 8'(sec_q), 8'h15);
        check("R8 year locked", year_q, 8'h30);
    endtask

    task automatic t_load_vs_tick();
        set_all(30, 7, 7, 3, 12, 34, 15);
        @(negedge clk);
        wr_unlock = 1; ld_sec = 1; sec_in = 7'h20; sec_tick = 1;
        @(negedge clk);
        wr_unlock = 0; ld_sec = 0; sec_tick = 0;
        check("R9 load wins", 8'(sec_q), 8'h20);
        tick_once();
        check("R9 count on", 8'(sec_q), 8'h21);
    endtask

    task automatic t_disabled();
        set_all(30, 7, 7, 3, 12, 34, 15);
        run_en = 0;
        tick_once();
        check("R10 tick ignored", 8'(sec_q), 8'h15);
        run_en = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        run_en = 1;
        t_seconds();
        t_midnight();
        t_wday_wrap();
        t_months();
        t_february();
        t_century();
        t_lock();
        t_load_vs_tick();
        t_disabled();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule